// File: doc/BRIEF.md
# Six-Channel Double-Buffered Pulse-Width Modulator

This block produces six independent pulse-width modulated outputs from a single clock. Each channel counts a period and a first-phase (duty) length in clock cycles, driving its output at a selectable active level for the first part of every period and at the opposite level for the remainder. Software programs it through a plain register port: a valid strobe, a write flag, a byte address, 32-bit write data, and read data that appears one cycle after a read request.

Period, duty and output level are written into shadow copies first. They reach the running counter only when software writes the control register with the commit bit set. On a channel that is already running, the commit waits for the end of the current period, so a waveform never mixes an old period with a new duty. On a channel that has not been launched, the commit applies at once. A separate launch bit starts a channel's counter the first time. After that, a channel is reconfigured with commits only, and is silenced by committing a duty of zero.

Top module: `pwm_multi`

## Requirements
- R1: Channel c (0..5) owns the 32-byte window starting at byte address c*0x20. Within it, control sits at offset 0x00, period at 0x08 and duty at 0x0C. A read returns the addressed register on `bus_rdata` one cycle after the request. Period and duty read back their shadow values.
- R2: Control bit 5 (continuous) and bit 8 (first-phase level) are stored and read back. Bit 0 (launch) and bit 2 (commit) act only as strobes and always read as zero.
- R3: After reset every register is zero, no channel is launched, and every output sits at its inactive level. With the level bit at zero, that inactive level is high, so all six outputs read 1.
- R4: Writing period or duty, without a commit, leaves the output waveform unchanged.
- R5: A control write with bit 0 set launches a channel that has not yet been launched, starting its counter at 0. On a launched channel, bit 0 has no effect.
- R6: A commit on a launched channel copies the shadow period, duty and level into the active set at the end of the current period, and the counter restarts at 0. On a channel that has not been launched, the commit takes effect in the same clock edge as the write.
- R7: A launched channel with active period P > 0 and active duty D is at its active level for the first min(D,P) cycles of each P-cycle period and at its inactive level for the rest. D = 0 or P = 0 holds the output at the inactive level.
- R8: With the active level bit at 1, the active level is high. With the bit at 0, the output is inverted: active level low, inactive level high.
- R9: Addresses at or above 0xB0, addresses that are not word-aligned, and offsets other than 0x00, 0x08 and 0x0C read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all counts are in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| pwm_out | output | 6 | One waveform output per channel |

## Verification
Each output is decoded from registered channel state with no further register. A launch, an immediate commit or a counter step therefore shows on `pwm_out` right after the clock edge that samples the write. A commit on a running channel shows right after the edge that ends the current period. Read data appears after the edge that samples the read. The bench holds a behavioural model that it advances on the same rising edge. It compares all six outputs against that model at every falling edge, and it compares read data at the falling edge that follows a read. Targeted checks count active cycles over a whole period to confirm duty limits and a deferred commit.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    // Byte offsets inside a channel window
    localparam int OFS_CTRL   = 'h00;
    localparam int OFS_PERIOD = 'h08;
    localparam int OFS_DUTY   = 'h0C;

    // Control register bit positions
    localparam int BIT_LAUNCH = 0;
    localparam int BIT_COMMIT = 2;
    localparam int BIT_CONT   = 5;
    localparam int BIT_LEVEL  = 8;

    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_CTRL   = 2'd1,
        SEL_PERIOD = 2'd2,
        SEL_DUTY   = 2'd3
    } reg_sel_t;
endpackage

// File: rtl/pwm_addr_dec.sv
module pwm_addr_dec
    import pwm_pkg::*;
#(
    parameter int NCH  = 6,
    parameter int AW   = 8,
    parameter int WIN  = 32,
    parameter int SPAN = 'hB0
) (
    input  logic                          acc_valid,
    input  logic                          acc_write,
    input  logic [AW-1:0]                 acc_addr,
    output reg_sel_t                      sel,
    output logic [AW-$clog2(WIN)-1:0]     ch_idx,
    output logic [NCH-1:0]                wr_ctrl,
    output logic [NCH-1:0]                wr_period,
    output logic [NCH-1:0]                wr_duty
);
    localparam int WB  = $clog2(WIN);
    localparam int CHW = AW - WB;

    logic [WB-1:0] ofs;
    logic          in_span;

    assign ofs     = acc_addr[WB-1:0];
    assign ch_idx  = acc_addr[AW-1:WB];
    assign in_span = (acc_addr < AW'(SPAN)) && (ch_idx < CHW'(NCH));

    always_comb begin
        sel = SEL_NONE;
        if (in_span) begin
            if (ofs == WB'(OFS_CTRL))        sel = SEL_CTRL;
            else if (ofs == WB'(OFS_PERIOD)) sel = SEL_PERIOD;
            else if (ofs == WB'(OFS_DUTY))   sel = SEL_DUTY;
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_wr
        logic hit;
        assign hit          = acc_valid && acc_write && (ch_idx == CHW'(c));
        assign wr_ctrl[c]   = hit && (sel == SEL_CTRL);
        assign wr_period[c] = hit && (sel == SEL_PERIOD);
        assign wr_duty[c]   = hit && (sel == SEL_DUTY);
    end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
    import pwm_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_ctrl,
    input  logic          wr_period,
    input  logic          wr_duty,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rd_ctrl,
    output logic [DW-1:0] rd_period,
    output logic [DW-1:0] rd_duty,
    output logic          wave
);
    typedef struct packed {
        logic [DW-1:0] sh_period;
        logic [DW-1:0] sh_duty;
        logic          sh_level;
        logic          sh_cont;
        logic [DW-1:0] act_period;
        logic [DW-1:0] act_duty;
        logic          act_level;
        logic          launched;
        logic          pending;
        logic [DW-1:0] cnt;
    } chan_t;

    chan_t st_q, st_d;
    logic  at_end;
    logic  commit_req;
    logic  launch_req;
    logic  in_first;

    assign at_end     = (st_q.act_period == '0) || (st_q.cnt == st_q.act_period - 1'b1);
    assign commit_req = wr_ctrl && wdata[BIT_COMMIT];
    assign launch_req = wr_ctrl && wdata[BIT_LAUNCH];

    always_comb begin
        st_d = st_q;
        // shadow writes
        if (wr_period) st_d.sh_period = wdata;
        if (wr_duty)   st_d.sh_duty   = wdata;
        if (wr_ctrl) begin
            st_d.sh_level = wdata[BIT_LEVEL];
            st_d.sh_cont  = wdata[BIT_CONT];
        end
        // running counter and deferred transfer at the period end
        if (st_q.launched) begin
            if (st_q.pending && at_end) begin
                st_d.act_period = st_q.sh_period;
                st_d.act_duty   = st_q.sh_duty;
                st_d.act_level  = st_q.sh_level;
                st_d.pending    = 1'b0;
                st_d.cnt        = '0;
            end else if (at_end) begin
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        // commit: immediate when idle, deferred when running
        if (commit_req) begin
            if (!st_q.launched) begin
                st_d.act_period = st_d.sh_period;
                st_d.act_duty   = st_d.sh_duty;
                st_d.act_level  = st_d.sh_level;
            end else begin
                st_d.pending = 1'b1;
            end
        end
        // first launch only
        if (launch_req && !st_q.launched) begin
            st_d.launched = 1'b1;
            st_d.cnt      = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_ctrl            = '0;
        rd_ctrl[BIT_CONT]  = st_q.sh_cont;
        rd_ctrl[BIT_LEVEL] = st_q.sh_level;
    end
    assign rd_period = st_q.sh_period;
    assign rd_duty   = st_q.sh_duty;

    assign in_first = st_q.launched && (st_q.act_period != '0) && (st_q.cnt < st_q.act_duty);
    assign wave     = in_first ? st_q.act_level : ~st_q.act_level;

    // R4: without a commit request or a pending transfer the active set holds
    a_r4_shadow_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.pending && !commit_req) |=>
            ($stable(st_q.act_period) && $stable(st_q.act_duty) && $stable(st_q.act_level)));

    // R6: a running channel changes its active set only at a period end
    a_r6_period_end_only: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.launched && !at_end) |=>
            ($stable(st_q.act_period) && $stable(st_q.act_duty) && $stable(st_q.act_level)));

    // R5: once launched, a channel stays launched
    a_r5_launch_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.launched |=> st_q.launched);

    // R7: the cycle counter never reaches the active period
    a_r7_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.launched && (st_q.act_period != '0)) |-> (st_q.cnt < st_q.act_period));
endmodule

// File: rtl/pwm_multi.sv
module pwm_multi
    import pwm_pkg::*;
#(
    parameter int NCH  = 6,
    parameter int DW   = 32,
    parameter int AW   = 8,
    parameter int WIN  = 32,
    parameter int SPAN = 'hB0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_valid,
    input  logic           bus_write,
    input  logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    output logic [NCH-1:0] pwm_out
);
    localparam int CHW = AW - $clog2(WIN);

    reg_sel_t       sel;
    logic [CHW-1:0] ch_idx;
    logic [NCH-1:0] wr_ctrl, wr_period, wr_duty;
    logic [DW-1:0]  rd_ctrl   [NCH];
    logic [DW-1:0]  rd_period [NCH];
    logic [DW-1:0]  rd_duty   [NCH];
    logic [DW-1:0]  rdata_d, rdata_q;

    pwm_addr_dec #(.NCH(NCH), .AW(AW), .WIN(WIN), .SPAN(SPAN)) u_dec (
        .acc_valid (bus_valid),
        .acc_write (bus_write),
        .acc_addr  (bus_addr),
        .sel       (sel),
        .ch_idx    (ch_idx),
        .wr_ctrl   (wr_ctrl),
        .wr_period (wr_period),
        .wr_duty   (wr_duty)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        pwm_chan #(.DW(DW)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_ctrl   (wr_ctrl[c]),
            .wr_period (wr_period[c]),
            .wr_duty   (wr_duty[c]),
            .wdata     (bus_wdata),
            .rd_ctrl   (rd_ctrl[c]),
            .rd_period (rd_period[c]),
            .rd_duty   (rd_duty[c]),
            .wave      (pwm_out[c])
        );
    end

    always_comb begin
        rdata_d = '0;
        if (bus_valid && !bus_write) begin
            for (int c = 0; c < NCH; c++) begin
                if (ch_idx == CHW'(c)) begin
                    case (sel)
                        SEL_CTRL:   rdata_d = rd_ctrl[c];
                        SEL_PERIOD: rdata_d = rd_period[c];
                        SEL_DUTY:   rdata_d = rd_duty[c];
                        default:    rdata_d = '0;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign bus_rdata = rdata_q;

    // R9: unmapped reads return zero
    a_r9_unmapped_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && (sel == SEL_NONE)) |=> (bus_rdata == '0));

    // R2: strobe bits never read back as set
    a_r2_strobes_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && (sel == SEL_CTRL)) |=>
            (!bus_rdata[BIT_LAUNCH] && !bus_rdata[BIT_COMMIT]));
endmodule

// File: tb/tb_pwm_multi.sv
module tb_pwm_multi;
    localparam int NCH = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [5:0]  pwm_out;

    int    n_checks = 0;
    int    n_fails  = 0;
    bit    cmp_on   = 1'b0;
    bit    done     = 1'b0;
    string cur_tag  = "R3";

    // behavioural model state
    logic [31:0] m_sp [NCH], m_sd [NCH], m_ap [NCH], m_ad [NCH], m_cnt [NCH];
    bit          m_sf [NCH], m_sc [NCH], m_af [NCH], m_run [NCH], m_pend [NCH];

    always #10 clk = ~clk;   // 50 MHz

    pwm_multi dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    function automatic bit m_mapped(input logic [7:0] a);
        return (a < 8'hB0) && (a[1:0] == 2'b00) &&
               ((a[4:0] == 5'h00) || (a[4:0] == 5'h08) || (a[4:0] == 5'h0C));
    endfunction

    function automatic logic [31:0] m_read(input logic [7:0] a);
        int c;
        if (!m_mapped(a)) return 32'h0;
        c = int'(a[7:5]);
        case (a[4:0])
            5'h00:   return (32'(m_sc[c]) << 5) | (32'(m_sf[c]) << 8);
            5'h08:   return m_sp[c];
            default: return m_sd[c];
        endcase
    endfunction

    function automatic bit m_wave(input int c);
        bit act;
        act = m_run[c] && (m_ap[c] != 0) && (m_cnt[c] < m_ad[c]);
        return act ? m_af[c] : !m_af[c];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                m_sp[c] = 0; m_sd[c] = 0; m_ap[c] = 0; m_ad[c] = 0; m_cnt[c] = 0;
                m_sf[c] = 0; m_sc[c] = 0; m_af[c] = 0; m_run[c] = 0; m_pend[c] = 0;
            end
        end else begin
            for (int c = 0; c < NCH; c++) begin
                bit ends, was_run, hit;
                ends    = (m_ap[c] == 0) || (m_cnt[c] == m_ap[c] - 1);
                was_run = m_run[c];
                if (was_run) begin
                    if (m_pend[c] && ends) begin
                        m_ap[c] = m_sp[c]; m_ad[c] = m_sd[c]; m_af[c] = m_sf[c];
                        m_pend[c] = 0; m_cnt[c] = 0;
                    end else begin
                        m_cnt[c] = ends ? 0 : m_cnt[c] + 1;
                    end
                end
                hit = bus_valid && bus_write && m_mapped(bus_addr) && (int'(bus_addr[7:5]) == c);
                if (hit) begin
                    case (bus_addr[4:0])
                        5'h08: m_sp[c] = bus_wdata;
                        5'h0C: m_sd[c] = bus_wdata;
                        default: begin
                            m_sf[c] = bus_wdata[8];
                            m_sc[c] = bus_wdata[5];
                            if (bus_wdata[2]) begin
                                if (!was_run) begin
                                    m_ap[c] = m_sp[c]; m_ad[c] = m_sd[c]; m_af[c] = m_sf[c];
                                end else m_pend[c] = 1;
                            end
                            if (bus_wdata[0] && !was_run) begin
                                m_run[c] = 1; m_cnt[c] = 0;
                            end
                        end
                    endcase
                end
            end
        end
    end

    // per-cycle comparison of all outputs against the model
    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            logic [5:0] exp;
            for (int c = 0; c < NCH; c++) exp[c] = m_wave(c);
            n_checks++;
            if (pwm_out !== exp) begin
                n_fails++;
                $display("FAIL %s pwm_out actual=%b expected=%b at %0t", cur_tag, pwm_out, exp, $time);
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        logic [31:0] exp;
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        exp = m_read(a);
        @(negedge clk);
        bus_valid = 1'b0;
        check(tag, bus_rdata, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // count active-high cycles of one output over n cycles
    task automatic count_high(input int c, input int n, output int k);
        k = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out[c]) k++;
        end
    endtask

    initial begin
        int k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R3: reset state, outputs inactive high
        check("R3 outputs after reset", 32'(pwm_out), 32'h3F);
        rd(8'h00, "R3 ctrl0 after reset");
        cmp_on = 1'b1;

        // R1 / R4: shadow writes, no commit
        cur_tag = "R4";
        wr(8'h08, 32'd10);
        wr(8'h0C, 32'd3);
        rd(8'h08, "R1 period0 readback");
        check("R1 period0 value", bus_rdata, 32'd10);
        rd(8'h0C, "R1 duty0 readback");
        check("R4 no commit output", 32'(pwm_out[0]), 32'h1);

        // R6 immediate commit on idle channel, R8 normal level
        cur_tag = "R6";
        wr(8'h00, 32'h124);
        check("R6 immediate commit level", 32'(pwm_out[0]), 32'h0);
        rd(8'h00, "R2 ctrl0 readback");
        check("R2 strobes read zero", bus_rdata, 32'h120);

        // R5 launch, R7 waveform
        cur_tag = "R7";
        wr(8'h00, 32'h121);
        count_high(0, 10, k);
        check("R7 duty 3 of 10", 32'(k), 32'd3);

        // other channels: full duty, zero duty, zero period, inverted
        wr(8'h28, 32'd8);  wr(8'h2C, 32'd8);  wr(8'h20, 32'h124); wr(8'h20, 32'h001);
        wr(8'h48, 32'd5);  wr(8'h4C, 32'd0);  wr(8'h40, 32'h124); wr(8'h40, 32'h001);
        wr(8'h68, 32'd0);  wr(8'h6C, 32'd4);  wr(8'h60, 32'h124); wr(8'h60, 32'h001);
        cur_tag = "R8";
        wr(8'h88, 32'd6);  wr(8'h8C, 32'd2);  wr(8'h80, 32'h024); wr(8'h80, 32'h001);
        count_high(1, 16, k);
        check("R7 duty >= period stays active", 32'(k), 32'd16);
        count_high(2, 10, k);
        check("R7 duty zero stays inactive", 32'(k), 32'd0);
        count_high(3, 8, k);
        check("R7 period zero stays inactive", 32'(k), 32'd0);
        count_high(4, 12, k);
        check("R8 inverted low for duty", 32'(k), 32'd8);

        // R4 on a running channel, then R6 deferred commit
        cur_tag = "R4";
        wr(8'h08, 32'd4);
        wr(8'h0C, 32'd1);
        idle(12);
        cur_tag = "R6";
        wr(8'h00, 32'h124);
        idle(12);
        count_high(0, 8, k);
        check("R6 new setting after period end", 32'(k), 32'd2);

        // R5 second launch ignored
        cur_tag = "R5";
        wr(8'h00, 32'h121);
        idle(10);
        count_high(0, 4, k);
        check("R5 relaunch no effect", 32'(k), 32'd1);

        // R9 unmapped accesses
        cur_tag = "R9";
        wr(8'hB0, 32'hFFFF_FFFF);
        wr(8'h09, 32'd2);
        wr(8'h04, 32'd2);
        wr(8'hB8, 32'd2);
        rd(8'hB0, "R9 read above span");
        rd(8'h04, "R9 read unused offset");
        rd(8'h09, "R9 read unaligned");
        rd(8'h08, "R9 period0 untouched");
        check("R9 period0 value", bus_rdata, 32'd4);

        // R1 last channel window
        cur_tag = "R1";
        wr(8'hA8, 32'd7);
        wr(8'hAC, 32'd5);
        rd(8'hA8, "R1 period5 readback");
        rd(8'hAC, "R1 duty5 readback");
        wr(8'hA0, 32'h125);
        count_high(5, 14, k);
        check("R1 channel 5 waveform", 32'(k), 32'd10);

        cmp_on = 1'b0;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule